// File: doc/BRIEF.md
# Line Error Performance Counters

This block keeps two line-error counters for a framed line receiver and presents them to a processor through byte-wide registers. The framing-bit error counter is 12 bits wide and the CRC error counter is 10 bits wide. Upstream detectors deliver errors as single-cycle pulses, one per error. A per-counter overflow-interrupt enable decides what a full counter does with the next event. When the enable is set, the counter rolls over and records an overflow. When it is clear, the counter stays at its maximum value.

Software reads each counter as a low byte followed by a high byte. The low-byte read captures the counter's upper bits into a shadow, so the two bytes describe the same instant. In normal mode the high-byte read clears the live count. In one-second latched mode a timebase pulse moves the live count into a holding register and restarts counting. Reads then return the held value and clear nothing. Read data is combinational from the address. Read side effects take place on the clock edge where `rd_i` is high.

Top module: `line_err_counters`

## Requirements
- R1: After reset every count, shadow, held value and status bit is zero, so every register address reads 0x00 and `irq_o` is 2'b00.
- R2: Each `frm_evt_i` pulse adds one to the framing counter (FRM_W bits). Its bits [7:0] read at 0x50. Its upper bits read in the low bits of 0x51, and the unused upper bits of 0x51 read as zero.
- R3: Each `crc_evt_i` pulse adds one to the CRC counter (CRC_W bits). Its bits [7:0] read at 0x52. Its upper bits read in the low bits of 0x53, and the unused upper bits of 0x53 read as zero.
- R4: With `ovf_ie_i[i]` set (bit 0 for framing, bit 1 for CRC), an event at the maximum count takes the counter to zero and sets status bit i.
- R5: With `ovf_ie_i[i]` clear, a counter at its maximum holds that value, ignores further events and sets no status bit.
- R6: A low-byte read copies the counter's upper bits into a shadow. The next high-byte read returns that shadow even if the counter has since changed.
- R7: With `latch_mode_i` low, a high-byte read clears the whole counter. An event in the same cycle leaves the counter at 1.
- R8: With `latch_mode_i` high, each `sec_pulse_i` copies the live count into a held register and restarts the live count at 0, or at 1 if an event arrives in the same cycle. Reads return the held value and never clear.
- R9: Status register 0x54 holds sticky overflow bits: bit 0 for framing and bit 1 for CRC. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R10: `irq_o[i]` is high exactly while status bit i and `ovf_ie_i[i]` are both set.
- R11: Any address other than 0x50 to 0x54 reads 0x00, and reading it changes no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| frm_evt_i | input | 1 | framing-bit error pulse |
| crc_evt_i | input | 1 | CRC error pulse |
| sec_pulse_i | input | 1 | one-second timebase pulse |
| latch_mode_i | input | 1 | selects one-second latched mode |
| ovf_ie_i | input | 2 | overflow-interrupt enables: bit 0 framing, bit 1 CRC |
| rd_i | input | 1 | register read strobe |
| wr_i | input | 1 | register write strobe |
| addr_i | input | ADDR_W | register byte address |
| wdata_i | input | 8 | write data |
| rdata_o | output | 8 | read data, combinational from `addr_i` |
| irq_o | output | 2 | overflow interrupts: bit 0 framing, bit 1 CRC |

## Verification
The bench builds the block with FRM_W=9 and CRC_W=10, so the framing counter tops out at 511 and the CRC counter at 1023. At these widths both counters can be swept across their full range, pushed through single and multiple wraps, and driven into saturation in a few thousand cycles. A shadow capture across a wrap that changes the upper bits also fits in a short run. Expected counts are computed as the pulse count modulo 2^W or capped at 2^W-1, and the whole 8-bit address space is swept to check the unmapped reads.

// File: rtl/lec_pkg.sv
package lec_pkg;
  localparam int unsigned OFF_FRM_LO = 0;
  localparam int unsigned OFF_FRM_HI = 1;
  localparam int unsigned OFF_CRC_LO = 2;
  localparam int unsigned OFF_CRC_HI = 3;
  localparam int unsigned OFF_STS    = 4;
  localparam int unsigned N_CNT      = 2;
  localparam int unsigned IDX_FRM    = 0;
  localparam int unsigned IDX_CRC    = 1;
endpackage

// File: rtl/lec_counter.sv
module lec_counter #(
  parameter int unsigned W = 12
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           evt_i,
  input  logic           sec_i,
  input  logic           latch_mode_i,
  input  logic           wrap_en_i,
  input  logic           rd_lo_i,
  input  logic           rd_hi_i,
  output logic [7:0]     lo_o,
  output logic [W-9:0]   hi_o,
  output logic           wrap_o
);
  localparam int unsigned HI_W = W - 8;
  localparam logic [W-1:0] MAX = {W{1'b1}};

  logic [W-1:0]    cnt_q, cnt_d, lat_q, src;
  logic [HI_W-1:0] shd_q;
  logic            restart, at_max;

  assign at_max  = (cnt_q == MAX);
  // latched mode restarts on the timebase; normal mode restarts on the high read
  assign restart = latch_mode_i ? sec_i : rd_hi_i;
  assign src     = latch_mode_i ? lat_q : cnt_q;

  always_comb begin
    cnt_d  = cnt_q;
    wrap_o = 1'b0;
    if (restart) begin
      cnt_d = {{(W-1){1'b0}}, evt_i};
    end else if (evt_i) begin
      if (!at_max) begin
        cnt_d = cnt_q + 1'b1;
      end else if (wrap_en_i) begin
        cnt_d  = '0;
        wrap_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lat_q <= '0;
      shd_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (latch_mode_i && sec_i) lat_q <= cnt_q;
      if (rd_lo_i) shd_q <= src[W-1:8];
    end
  end

  assign lo_o = src[7:0];
  assign hi_o = shd_q;
endmodule

// File: rtl/lec_regif.sv
module lec_regif
  import lec_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BASE_ADDR = 'h50,
  parameter int unsigned FRM_HI_W  = 4,
  parameter int unsigned CRC_HI_W  = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rd_i,
  input  logic                wr_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [7:0]          wdata_i,
  input  logic [7:0]          frm_lo_i,
  input  logic [FRM_HI_W-1:0] frm_hi_i,
  input  logic [7:0]          crc_lo_i,
  input  logic [CRC_HI_W-1:0] crc_hi_i,
  input  logic [N_CNT-1:0]    wrap_i,
  output logic                rd_frm_lo_o,
  output logic                rd_frm_hi_o,
  output logic                rd_crc_lo_o,
  output logic                rd_crc_hi_o,
  output logic [N_CNT-1:0]    sts_o,
  output logic [7:0]          rdata_o
);
  localparam logic [ADDR_W-1:0] A_FRM_LO = ADDR_W'(BASE_ADDR + OFF_FRM_LO);
  localparam logic [ADDR_W-1:0] A_FRM_HI = ADDR_W'(BASE_ADDR + OFF_FRM_HI);
  localparam logic [ADDR_W-1:0] A_CRC_LO = ADDR_W'(BASE_ADDR + OFF_CRC_LO);
  localparam logic [ADDR_W-1:0] A_CRC_HI = ADDR_W'(BASE_ADDR + OFF_CRC_HI);
  localparam logic [ADDR_W-1:0] A_STS    = ADDR_W'(BASE_ADDR + OFF_STS);

  logic [N_CNT-1:0] sts_q, clr;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i[7:N_CNT];

  assign rd_frm_lo_o = rd_i && (addr_i == A_FRM_LO);
  assign rd_frm_hi_o = rd_i && (addr_i == A_FRM_HI);
  assign rd_crc_lo_o = rd_i && (addr_i == A_CRC_LO);
  assign rd_crc_hi_o = rd_i && (addr_i == A_CRC_HI);

  assign clr = (wr_i && addr_i == A_STS) ? wdata_i[N_CNT-1:0] : '0;

  // a wrap in the clearing cycle keeps the bit set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= (sts_q & ~clr) | wrap_i;
  end
  assign sts_o = sts_q;

  always_comb begin
    rdata_o = 8'h00;
    if (addr_i == A_FRM_LO)      rdata_o = frm_lo_i;
    else if (addr_i == A_FRM_HI) rdata_o = 8'(frm_hi_i);
    else if (addr_i == A_CRC_LO) rdata_o = crc_lo_i;
    else if (addr_i == A_CRC_HI) rdata_o = 8'(crc_hi_i);
    else if (addr_i == A_STS)    rdata_o = 8'(sts_q);
  end
endmodule

// File: rtl/line_err_counters.sv
module line_err_counters
  import lec_pkg::*;
#(
  parameter int unsigned FRM_W     = 12,
  parameter int unsigned CRC_W     = 10,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BASE_ADDR = 'h50
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frm_evt_i,
  input  logic              crc_evt_i,
  input  logic              sec_pulse_i,
  input  logic              latch_mode_i,
  input  logic [1:0]        ovf_ie_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic [1:0]        irq_o
);
  localparam int unsigned FRM_HI_W = FRM_W - 8;
  localparam int unsigned CRC_HI_W = CRC_W - 8;

  logic [7:0]          frm_lo, crc_lo;
  logic [FRM_HI_W-1:0] frm_hi;
  logic [CRC_HI_W-1:0] crc_hi;
  logic [N_CNT-1:0]    wrap, sts;
  logic                rd_frm_lo, rd_frm_hi, rd_crc_lo, rd_crc_hi;

  lec_counter #(.W(FRM_W)) u_frm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .evt_i        (frm_evt_i),
    .sec_i        (sec_pulse_i),
    .latch_mode_i (latch_mode_i),
    .wrap_en_i    (ovf_ie_i[IDX_FRM]),
    .rd_lo_i      (rd_frm_lo),
    .rd_hi_i      (rd_frm_hi),
    .lo_o         (frm_lo),
    .hi_o         (frm_hi),
    .wrap_o       (wrap[IDX_FRM])
  );

  lec_counter #(.W(CRC_W)) u_crc (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .evt_i        (crc_evt_i),
    .sec_i        (sec_pulse_i),
    .latch_mode_i (latch_mode_i),
    .wrap_en_i    (ovf_ie_i[IDX_CRC]),
    .rd_lo_i      (rd_crc_lo),
    .rd_hi_i      (rd_crc_hi),
    .lo_o         (crc_lo),
    .hi_o         (crc_hi),
    .wrap_o       (wrap[IDX_CRC])
  );

  lec_regif #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR),
    .FRM_HI_W  (FRM_HI_W),
    .CRC_HI_W  (CRC_HI_W)
  ) u_regif (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_i        (rd_i),
    .wr_i        (wr_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .frm_lo_i    (frm_lo),
    .frm_hi_i    (frm_hi),
    .crc_lo_i    (crc_lo),
    .crc_hi_i    (crc_hi),
    .wrap_i      (wrap),
    .rd_frm_lo_o (rd_frm_lo),
    .rd_frm_hi_o (rd_frm_hi),
    .rd_crc_lo_o (rd_crc_lo),
    .rd_crc_hi_o (rd_crc_hi),
    .sts_o       (sts),
    .rdata_o     (rdata_o)
  );

  assign irq_o = sts & ovf_ie_i;
endmodule

// File: rtl/lec_checker.sv
module lec_checker
  import lec_pkg::*;
#(
  parameter int unsigned FRM_W     = 12,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BASE_ADDR = 'h50
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frm_evt_i,
  input logic              sec_pulse_i,
  input logic              latch_mode_i,
  input logic [1:0]        ovf_ie_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        wdata_i,
  input logic [7:0]        rdata_o,
  input logic [1:0]        irq_o,
  input logic [FRM_W-1:0]  frm_cnt_i,
  input logic              frm_wrap_i,
  input logic [1:0]        sts_i
);
  localparam logic [FRM_W-1:0]  MAX      = {FRM_W{1'b1}};
  localparam logic [ADDR_W-1:0] A_FRM_HI = ADDR_W'(BASE_ADDR + OFF_FRM_HI);
  localparam logic [ADDR_W-1:0] A_STS    = ADDR_W'(BASE_ADDR + OFF_STS);
  localparam logic [ADDR_W-1:0] A_FIRST  = ADDR_W'(BASE_ADDR);

  logic rd_frm_hi, sts_wr;
  assign rd_frm_hi = rd_i && (addr_i == A_FRM_HI);
  assign sts_wr    = wr_i && (addr_i == A_STS);

  AST_WRAP_TO_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_wrap_i |=> frm_cnt_i == '0); // R4

  AST_STS_SET_BY_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_i[0]) |-> $past(frm_wrap_i)); // R4

  AST_SAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_cnt_i == MAX && !ovf_ie_i[0] && !latch_mode_i && !rd_frm_hi) |=> frm_cnt_i == MAX); // R5

  AST_HI_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!latch_mode_i && rd_frm_hi && !frm_evt_i) |=> frm_cnt_i == '0); // R7

  AST_LATCH_NO_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_mode_i && !sec_pulse_i && !frm_evt_i) |=> frm_cnt_i == $past(frm_cnt_i)); // R8

  AST_STS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_i[0] && !(sts_wr && wdata_i[0])) |=> sts_i[0]); // R9

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o[1] |-> ovf_ie_i[1]); // R10

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i < A_FIRST || addr_i > A_STS) |-> rdata_o == 8'h00); // R11
endmodule

bind line_err_counters lec_checker #(
  .FRM_W     (FRM_W),
  .ADDR_W    (ADDR_W),
  .BASE_ADDR (BASE_ADDR)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frm_evt_i    (frm_evt_i),
  .sec_pulse_i  (sec_pulse_i),
  .latch_mode_i (latch_mode_i),
  .ovf_ie_i     (ovf_ie_i),
  .rd_i         (rd_i),
  .wr_i         (wr_i),
  .addr_i       (addr_i),
  .wdata_i      (wdata_i),
  .rdata_o      (rdata_o),
  .irq_o        (irq_o),
  .frm_cnt_i    (u_frm.cnt_q),
  .frm_wrap_i   (u_frm.wrap_o),
  .sts_i        (u_regif.sts_q)
);

// File: tb/line_err_counters_bench.sv
`timescale 1ns/1ps
module line_err_counters_bench;
  localparam int FRM_W = 9;
  localparam int CRC_W = 10;
  localparam int FMAX  = (1 << FRM_W) - 1;
  localparam int CMAX  = (1 << CRC_W) - 1;

  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       frm_evt = 0, crc_evt = 0, sec = 0, latch_mode = 0;
  logic [1:0] ovf_ie = 2'b00;
  logic       rd = 0, wr = 0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic [7:0] rdata;
  logic [1:0] irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  line_err_counters #(.FRM_W(FRM_W), .CRC_W(CRC_W)) u_line_err_counters (
    .clk_i(clk), .rst_ni(rst_ni), .frm_evt_i(frm_evt), .crc_evt_i(crc_evt),
    .sec_pulse_i(sec), .latch_mode_i(latch_mode), .ovf_ie_i(ovf_ie),
    .rd_i(rd), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic rd_byte(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); rd = 1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd = 0;
  endtask

  task automatic wr_byte(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  // low byte then high byte; returns the value and the unused high bits
  task automatic rd_cnt(input logic [7:0] lo_a, input int w, output int v, output int junk);
    logic [7:0] lo, hi;
    rd_byte(lo_a, lo);
    rd_byte(lo_a + 8'd1, hi);
    v    = int'(hi) * 256 + int'(lo);
    junk = int'(hi) >> (w - 8);
  endtask

  task automatic pulse(input bit f, input bit c, input int n);
    if (n > 0) begin
      @(negedge clk); frm_evt = f; crc_evt = c;
      repeat (n) @(negedge clk);
      frm_evt = 0; crc_evt = 0;
    end
  endtask

  task automatic sec_tick(input bit f);
    @(negedge clk); sec = 1; frm_evt = f;
    @(negedge clk); sec = 0; frm_evt = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int v, j;
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_ni = 1;

    // R1 reset state
    for (int a = 'h50; a <= 'h54; a++) begin
      rd_byte(8'(a), d);
      chk($sformatf("R1 reset addr %0h", a), int'(d), 0);
    end
    chk("R1 irq after reset", int'(irq), 0);

    // R2 framing sweep, R7 clear by high read
    for (int n = 0; n <= FMAX; n += 23) begin
      pulse(1, 0, n);
      rd_cnt(8'h50, FRM_W, v, j);
      chk($sformatf("R2 frm count n=%0d", n), v, n);
      chk("R2 frm upper bits zero", j, 0);
      rd_cnt(8'h50, FRM_W, v, j);
      chk("R7 frm cleared by high read", v, 0);
    end
    pulse(1, 0, FMAX);
    rd_cnt(8'h50, FRM_W, v, j);
    chk("R2 frm at max", v, FMAX);

    // R3 CRC sweep
    for (int n = 0; n <= CMAX; n += 61) begin
      pulse(0, 1, n);
      rd_cnt(8'h52, CRC_W, v, j);
      chk($sformatf("R3 crc count n=%0d", n), v, n);
      chk("R3 crc upper bits zero", j, 0);
      rd_cnt(8'h52, CRC_W, v, j);
      chk("R7 crc cleared by high read", v, 0);
    end

    // R5 saturation
    ovf_ie = 2'b00;
    pulse(1, 1, CMAX + 80);
    rd_cnt(8'h50, FRM_W, v, j);
    chk("R5 frm saturates", v, FMAX);
    rd_cnt(8'h52, CRC_W, v, j);
    chk("R5 crc saturates", v, CMAX);
    rd_byte(8'h54, d);
    chk("R5 no status on saturation", int'(d), 0);

    // R4 wrap, R10 irq, R9 sticky clear
    ovf_ie = 2'b11;
    pulse(1, 0, FMAX + 1 + 3);
    rd_cnt(8'h50, FRM_W, v, j);
    chk("R4 frm wraps", v, 3);
    rd_byte(8'h54, d);
    chk("R4 frm status set", int'(d), 1);
    chk("R10 frm irq", int'(irq), 1);
    pulse(0, 1, CMAX + 1 + 7);
    rd_cnt(8'h52, CRC_W, v, j);
    chk("R4 crc wraps", v, 7);
    rd_byte(8'h54, d);
    chk("R4 both status set", int'(d), 3);
    ovf_ie = 2'b10;
    #1 chk("R10 irq masked by enable", int'(irq), 2);
    wr_byte(8'h54, 8'h00);
    rd_byte(8'h54, d);
    chk("R9 write 0 keeps status", int'(d), 3);
    wr_byte(8'h54, 8'h01);
    rd_byte(8'h54, d);
    chk("R9 write 1 clears bit 0", int'(d), 2);
    wr_byte(8'h54, 8'h02);
    rd_byte(8'h54, d);
    chk("R9 write 1 clears bit 1", int'(d), 0);
    chk("R10 irq low after clear", int'(irq), 0);
    ovf_ie = 2'b11;
    pulse(1, 0, 3 * (FMAX + 1) + 1);
    rd_cnt(8'h50, FRM_W, v, j);
    chk("R4 frm multiple wraps", v, 1);
    wr_byte(8'h54, 8'h03);

    // R6 shadow coherency
    pulse(1, 0, 200);
    rd_byte(8'h50, d);
    chk("R6 low byte", int'(d), 200);
    pulse(1, 0, 100);
    rd_byte(8'h51, d);
    chk("R6 high from shadow (0)", int'(d), 0);
    pulse(1, 0, 300);
    rd_byte(8'h50, d);
    chk("R6 low byte 300", int'(d), 300 % 256);
    pulse(1, 0, 300);
    rd_byte(8'h51, d);
    chk("R6 high from shadow (1)", int'(d), 1);
    rd_cnt(8'h50, FRM_W, v, j);
    chk("R7 high read cleared all", v, 0);
    wr_byte(8'h54, 8'h03);

    // R7 coincident event with clearing read
    pulse(1, 0, 5);
    rd_byte(8'h50, d);
    @(negedge clk); rd = 1; addr = 8'h51; frm_evt = 1;
    @(negedge clk); rd = 0; frm_evt = 0;
    rd_cnt(8'h50, FRM_W, v, j);
    chk("R7 coincident event kept", v, 1);

    // R8 latched mode
    @(negedge clk); latch_mode = 1;
    pulse(1, 0, 10);
    pulse(0, 1, 4);
    rd_cnt(8'h50, FRM_W, v, j);
    chk("R8 held value before tick", v, 0);
    sec_tick(0);
    rd_cnt(8'h50, FRM_W, v, j);
    chk("R8 frm held after tick", v, 10);
    rd_cnt(8'h50, FRM_W, v, j);
    chk("R8 read does not clear", v, 10);
    rd_cnt(8'h52, CRC_W, v, j);
    chk("R8 crc held after tick", v, 4);
    pulse(1, 0, 6);
    sec_tick(1);
    pulse(1, 0, 2);
    rd_cnt(8'h50, FRM_W, v, j);
    chk("R8 second interval held", v, 6);
    sec_tick(0);
    rd_cnt(8'h50, FRM_W, v, j);
    chk("R8 coincident event counted as 1", v, 3);
    rd_cnt(8'h52, CRC_W, v, j);
    chk("R8 crc restarted", v, 0);
    @(negedge clk); latch_mode = 0;
    rd_cnt(8'h50, FRM_W, v, j);
    chk("R8 live restarted by tick", v, 0);

    // R11 unmapped addresses
    pulse(1, 1, 7);
    for (int a = 0; a < 256; a++) begin
      if (a < 'h50 || a > 'h54) begin
        rd_byte(8'(a), d);
        chk($sformatf("R11 unmapped %0h", a), int'(d), 0);
      end
    end
    rd_cnt(8'h50, FRM_W, v, j);
    chk("R11 unmapped reads leave count", v, 7);

    finish_run();
  end
endmodule